// File: doc/BRIEF.md
# Iterative Two-Rate Shift Unit

This block is a sequential 32-bit shifter meant to sit beside the ALU of a small multicycle integer core. A caller presents an operand, a shift distance and an operation code together with a one-cycle start strobe. The unit then moves the operand toward its final position over several clocks. It makes coarse moves of eight bit positions while eight or more remain, and then single-position moves until the distance is used up. It supports left logical, right logical and right arithmetic shifts.

The number of clocks a shift takes therefore depends on the distance. A distance of n costs n/8 coarse steps plus n%8 fine steps. A distance of zero finishes on the next clock with no steps. While a shift is in progress the unit raises `busy` and ignores further start requests. When the shift finishes it raises `done` for one clock. The result remains on `result` until the next start is accepted.

Top module: `iter_shifter`

## Requirements
- R1: With `op` = 2'b00 the final result is the operand shifted left by `amt` positions, with zeros entering at bit 0.
- R2: With `op` = 2'b01 or 2'b11 the final result is the operand shifted right by `amt` positions, with zeros entering at bit 31.
- R3: With `op` = 2'b10 the final result is the operand shifted right by `amt` positions, with copies of the original bit 31 entering every vacated upper position.
- R4: For an accepted start with `amt` = n > 0, `busy` is high from the cycle after the start cycle, and `done` is high exactly n/8 + n%8 cycles after the start cycle plus one. `busy` drops in that same cycle.
- R5: For an accepted start with `amt` = 0, `busy` stays low, and `done` is high in the cycle after the start cycle with `result` equal to the operand.
- R6: A start presented while `busy` is high is ignored: the running shift finishes with its original operand, distance and timing.
- R7: `done` is high for a single cycle per accepted start, and `busy` and `done` are never high together.
- R8: While `busy` is low and no start is presented, `result` does not change, whatever the other inputs do.
- R9: A synchronous active-high `rst` clears `busy`, `done` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a shift; accepted only when not busy |
| op | input | 2 | Operation: 00 left logical, 01/11 right logical, 10 right arithmetic |
| operand | input | 32 | Value to shift, captured on an accepted start |
| amt | input | 5 | Shift distance, captured on an accepted start |
| result | output | 32 | Shifted value, valid from `done` until the next accepted start |
| busy | output | 1 | High while shift steps are still pending |
| done | output | 1 | One-cycle pulse marking completion |

## Verification
The bound checker watches the handshake on every cycle. It checks that `busy` and `done` are exclusive, that `done` lasts one cycle, and that a busy period always ends in `done`. It also checks that an accepted nonzero start raises `busy`, that a zero distance returns the operand on the next clock, and that `result` holds while the unit is idle. Whether the shifted value is correct for each operation and distance, the exact step count set by the coarse/fine split, and the discarding of starts made while busy are shown only by the bench. The bench compares every cycle against its behavioural model across all distances and operations.

// File: rtl/iter_shift_pkg.sv
package iter_shift_pkg;

   typedef enum logic [1:0] {
      SH_SLL = 2'b00,
      SH_SRL = 2'b01,
      SH_SRA = 2'b10,
      SH_ALT = 2'b11
   } shift_op_e;

endpackage

// File: rtl/iter_shift_step.sv
module iter_shift_step #(
   parameter int DATA_W = 32,
   parameter int STEP   = 1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [1:0]        op,
   output logic [DATA_W-1:0] dout
);
   import iter_shift_pkg::*;

   generate
      if (STEP < 1 || STEP >= DATA_W) begin : g_bad_step
         $error("iter_shift_step: STEP must lie in 1..DATA_W-1");
      end
   endgenerate

   always_comb begin
      case (shift_op_e'(op))
         SH_SLL:  dout = din << STEP;
         SH_SRA:  dout = $signed(din) >>> STEP;
         default: dout = din >> STEP;
      endcase
   end

endmodule

// File: rtl/iter_shift_ctrl.sv
module iter_shift_ctrl #(
   parameter int AMT_W       = 5,
   parameter int COARSE_STEP = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [AMT_W-1:0] amt,
   output logic             load,
   output logic             advance,
   output logic             coarse,
   output logic             busy,
   output logic             done
);
   localparam logic [AMT_W-1:0] COARSE_AMT = AMT_W'(COARSE_STEP);
   localparam logic [AMT_W-1:0] FINE_AMT   = AMT_W'(1);

   logic [AMT_W-1:0] remain_q;
   logic [AMT_W-1:0] remain_next;

   assign load        = start && !busy;
   assign advance     = busy;
   assign coarse      = (remain_q >= COARSE_AMT);
   assign remain_next = remain_q - (coarse ? COARSE_AMT : FINE_AMT);

   always_ff @(posedge clk) begin
      if (rst) begin
         remain_q <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            remain_q <= amt;
            if (amt == '0) begin
               done <= 1'b1;
            end else begin
               busy <= 1'b1;
            end
         end else if (busy) begin
            remain_q <= remain_next;
            if (remain_next == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/iter_shifter.sv
module iter_shifter #(
   parameter int DATA_W      = 32,
   parameter int COARSE_STEP = 8,
   localparam int AMT_W      = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] operand,
   input  logic [AMT_W-1:0]  amt,
   output logic [DATA_W-1:0] result,
   output logic              busy,
   output logic              done
);
   localparam int N_RATES = 2;

   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("iter_shifter: DATA_W must be a power of two of at least 2");
      end
      if (COARSE_STEP < 2 || COARSE_STEP >= DATA_W) begin : g_bad_coarse
         $error("iter_shifter: COARSE_STEP must lie in 2..DATA_W-1");
      end
   endgenerate

   logic              load;
   logic              advance;
   logic              coarse;
   logic [1:0]        op_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] stepped [N_RATES];

   iter_shift_ctrl #(
      .AMT_W       (AMT_W),
      .COARSE_STEP (COARSE_STEP)
   ) ctrl_i (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .amt     (amt),
      .load    (load),
      .advance (advance),
      .coarse  (coarse),
      .busy    (busy),
      .done    (done)
   );

   generate
      for (genvar g = 0; g < N_RATES; g++) begin : g_rate
         localparam int STEP = (g == 0) ? COARSE_STEP : 1;
         iter_shift_step #(
            .DATA_W (DATA_W),
            .STEP   (STEP)
         ) step_i (
            .din  (acc_q),
            .op   (op_q),
            .dout (stepped[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         op_q  <= '0;
      end else if (load) begin
         acc_q <= operand;
         op_q  <= op;
      end else if (advance) begin
         acc_q <= coarse ? stepped[0] : stepped[1];
      end
   end

   assign result = acc_q;

endmodule

// File: rtl/iter_shifter_chk.sv
module iter_shifter_chk #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic [DATA_W-1:0] operand,
   input logic [AMT_W-1:0]  amt,
   input logic [DATA_W-1:0] result,
   input logic              busy,
   input logic              done
);

   // R7
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> !done);

   // R4
   busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (start && !busy && amt != '0) |=> busy);

   // R4
   busy_end_chk: assert property (@(posedge clk) disable iff (rst)
      busy |=> (busy || done));

   // R5
   zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
      (start && !busy && amt == '0) |=> (done && !busy && result == $past(operand)));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> $stable(result));

endmodule

bind iter_shifter iter_shifter_chk #(
   .DATA_W (DATA_W),
   .AMT_W  (AMT_W)
) chk_i (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .operand (operand),
   .amt     (amt),
   .result  (result),
   .busy    (busy),
   .done    (done)
);

// File: tb/iter_shifter_tb_top.sv
`timescale 1ns/1ps
module iter_shifter_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] operand = '0;
   logic [4:0]  amt = '0;
   logic [31:0] result;
   logic        busy;
   logic        done;

   int    checks = 0;
   int    errors = 0;
   string cur_tag = "R9";
   bit    cmp_on = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   // behavioural reference state
   bit          m_busy = 1'b0;
   bit          m_done = 1'b0;
   int          m_left = 0;
   logic [31:0] m_result = '0;
   logic [31:0] m_pending = '0;

   always #2.5 clk = ~clk;

   iter_shifter dut_i (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .op      (op),
      .operand (operand),
      .amt     (amt),
      .result  (result),
      .busy    (busy),
      .done    (done)
   );

   function automatic logic [31:0] ref_shift(input logic [1:0] o, input logic [31:0] v, input int n);
      case (o)
         2'b00:   return v << n;
         2'b10:   return $signed(v) >>> n;
         default: return v >> n;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_busy <= 1'b0; m_done <= 1'b0; m_left <= 0; m_result <= '0;
      end else if (start && !m_busy) begin
         int lat;
         lat = amt / 8 + amt % 8;
         if (lat == 0) begin
            m_done <= 1'b1; m_result <= operand;
         end else begin
            m_busy <= 1'b1; m_done <= 1'b0; m_left <= lat;
            m_pending <= ref_shift(op, operand, int'(amt));
         end
      end else if (m_busy) begin
         m_left <= m_left - 1;
         if (m_left == 1) begin
            m_busy <= 1'b0; m_done <= 1'b1; m_result <= m_pending;
         end
      end else begin
         m_done <= 1'b0;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         checks++;
         if (busy !== m_busy) begin
            errors++;
            $display("FAIL %s busy got %0b exp %0b", cur_tag, busy, m_busy);
         end
         checks++;
         if (done !== m_done) begin
            errors++;
            $display("FAIL %s done got %0b exp %0b", cur_tag, done, m_done);
         end
         if (!m_busy) begin
            checks++;
            if (result !== m_result) begin
               errors++;
               $display("FAIL %s result got %h exp %h", cur_tag, result, m_result);
            end
         end
      end
   end

   function automatic string op_tag(input logic [1:0] o, input int n);
      if (n == 0) return "R5";
      if (o == 2'b00) return "R1";
      if (o == 2'b10) return "R3";
      return "R2";
   endfunction

   task automatic next_seed();
      seed = seed * 32'd1103515245 + 32'd12345;
   endtask

   task automatic do_op(input logic [1:0] o, input logic [31:0] v, input int n, input bit poke);
      @(negedge clk);
      op = o; operand = v; amt = 5'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke && m_busy) begin
         // R6: a second request while shifting must be dropped
         op = 2'b00; operand = ~v; amt = 5'd3; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cmp_on = 1'b1;
      cur_tag = "R9";
      repeat (2) @(negedge clk);
      rst = 1'b0;

      for (int o = 0; o < 4; o++) begin
         for (int n = 0; n < 32; n++) begin
            next_seed();
            cur_tag = op_tag(2'(o), n);
            do_op(2'(o), (n % 3 == 0) ? (seed | 32'h8000_0000) : seed, n, 1'b0);
         end
      end

      cur_tag = "R4";
      do_op(2'b10, 32'hF00D_0001, 31, 1'b0);
      do_op(2'b01, 32'h8000_0000, 8, 1'b0);
      do_op(2'b00, 32'h0000_0001, 16, 1'b0);

      cur_tag = "R6";
      for (int n = 9; n < 32; n += 5) begin
         next_seed();
         do_op(2'b10, seed | 32'h8000_0000, n, 1'b1);
      end

      cur_tag = "R7";
      do_op(2'b01, 32'hDEAD_BEEF, 0, 1'b0);
      do_op(2'b00, 32'hCAFE_0000, 0, 1'b0);

      cur_tag = "R8";
      do_op(2'b10, 32'hA5A5_5A5A, 13, 1'b0);
      for (int k = 0; k < 6; k++) begin
         next_seed();
         @(negedge clk);
         operand = seed; amt = seed[4:0]; op = seed[6:5];
      end

      cur_tag = "R9";
      do_op(2'b00, 32'h1234_5678, 20, 1'b0);
      @(negedge clk);
      op = 2'b01; operand = 32'hFFFF_FFFF; amt = 5'd30; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired in %s got running exp finished", cur_tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule